// File: doc/BRIEF.md
# Unified Reservation Station Pool

This block is the waiting area between instruction issue and the two execution units of a single-issue out-of-order core. It holds four stations, each shared by every instruction kind. A station records whether its instruction is a multiply, the two source operands (each either a value or the tag of the result it is waiting for), the destination tag and an age stamp. Result broadcasts are matched by tag against every pending source, and the matching sources take the broadcast value.

In every cycle the pool may dispatch up to two instructions. The oldest ready multiply goes to the multiply unit, but only while that unit says it can accept work. The oldest ready non-multiply goes to the ALU under the same rule for the ALU. A station is released at the clock edge where its instruction is dispatched. A new instruction can therefore be written into it in that same cycle, which is the first execute cycle of the instruction that leaves. `full` tells the issue stage that no station can take an instruction in the current cycle.

Top module: `rsPool`

## Requirements
- R1: After reset no station holds an instruction: `mulGo`, `aluGo` and `full` are all 0.
- R2: An instruction is accepted when `issueValid` is 1 and `full` is 0 in the same cycle. When `full` is 1 the offered instruction is ignored and is never dispatched.
- R3: A pending source whose tag equals `bcTag` while `bcValid` is 1 takes `bcData`. The instruction can be dispatched no earlier than the cycle after that broadcast. It is never dispatched in the broadcast cycle itself, and never in its own issue cycle.
- R4: When `mulReady` is 1 and at least one station holds a multiply (`issueIsMul`=1 at issue) with both sources ready, `mulGo` is 1 and the outputs carry the oldest such instruction's operands and destination tag. When `mulReady` is 0, `mulGo` is 0.
- R5: The same selection rule applies to instructions with `issueIsMul`=0 on the ALU side, gated by `aluReady`. A multiply and an ALU instruction may both be dispatched in one cycle, always from different stations.
- R6: A dispatched station is freed at the edge of its dispatch cycle. `full` is 1 exactly when all four stations are occupied and none is dispatched in the current cycle, so a new instruction issued during a dispatch cycle is accepted.
- R7: If a broadcast with a tag equal to a pending source's tag arrives in the same cycle that the instruction is issued, the value is captured at issue and is not lost.
- R8: Age order remains correct after the age counter wraps around. This holds as long as the span of issue numbers among the instructions held at one time is below 2^(AGE_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issueValid | input | 1 | An instruction is offered this cycle |
| issueIsMul | input | 1 | 1 = multiply, 0 = any other instruction |
| issueSrc1Ready | input | 1 | Source 1 value is present |
| issueSrc1Val | input | DATA_W | Source 1 value |
| issueSrc1Tag | input | TAG_W | Producer tag of source 1 when it is not ready |
| issueSrc2Ready | input | 1 | Source 2 value is present |
| issueSrc2Val | input | DATA_W | Source 2 value |
| issueSrc2Tag | input | TAG_W | Producer tag of source 2 when it is not ready |
| issueDstTag | input | TAG_W | Tag of this instruction's result |
| full | output | 1 | No station can accept an instruction this cycle |
| bcValid | input | 1 | A result is broadcast this cycle |
| bcTag | input | TAG_W | Tag of the broadcast result |
| bcData | input | DATA_W | Broadcast result value |
| mulReady | input | 1 | Multiply unit can accept an instruction |
| aluReady | input | 1 | ALU can accept an instruction |
| mulGo | output | 1 | A multiply is dispatched this cycle |
| mulSrc1 | output | DATA_W | Source 1 of the dispatched multiply |
| mulSrc2 | output | DATA_W | Source 2 of the dispatched multiply |
| mulDstTag | output | TAG_W | Destination tag of the dispatched multiply |
| aluGo | output | 1 | A non-multiply is dispatched this cycle |
| aluSrc1 | output | DATA_W | Source 1 of the dispatched ALU instruction |
| aluSrc2 | output | DATA_W | Source 2 of the dispatched ALU instruction |
| aluDstTag | output | TAG_W | Destination tag of the dispatched ALU instruction |

## Verification
The dispatch outputs and `full` depend combinationally on the registered stations and on that cycle's `mulReady`/`aluReady`. They are therefore due in the same cycle as the stimulus that sets them, while an issue or a broadcast can affect dispatch only one cycle later. The bench drives every input on the falling edge and samples one time unit afterwards. It compares against a queue-based reference model whose state advances once per cycle. Directed sequences pin down the one-cycle wake-up delay, capture at issue, refill during a dispatch cycle and the dropping of an instruction offered while `full` is 1. A long randomized run then carries the age counter through many wraps.

// File: rtl/rsPkg.sv
package rsPkg;
  localparam int unsigned RS_COUNT = 4;
  localparam int unsigned RS_IDX_W = $clog2(RS_COUNT);

  typedef logic [RS_IDX_W-1:0] rsIdx_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [RS_COUNT-1:0] alloc;   // one-hot station written this cycle
    rsIdx_t              mulIdx;  // station feeding the multiply unit
    rsIdx_t              aluIdx;  // station feeding the ALU
  } rsStrobe_t;
endpackage

// File: rtl/rsOldestPick.sv
module rsOldestPick #(
  parameter int unsigned N     = 4,
  parameter int unsigned AGE_W = 5,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N-1:0]            cand,
  input  logic [N-1:0][AGE_W-1:0] ages,
  output logic                    anyWin,
  output logic [N-1:0]            winVec,
  output logic [IDX_W-1:0]        winIdx
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic beatsAll;
    logic [AGE_W-1:0] diff;
    always_comb begin
      beatsAll = 1'b1;
      diff     = '0;
      for (int j = 0; j < N; j++) begin
        if (j != i && cand[j]) begin
          // wraparound-safe: i older than j when (i - j) is negative
          diff = ages[i] - ages[j];
          if (!diff[AGE_W-1]) beatsAll = 1'b0;
        end
      end
    end
    assign winVec[i] = cand[i] & beatsAll;
  end

  always_comb begin
    winIdx = '0;
    for (int i = 0; i < N; i++) begin
      if (winVec[i]) winIdx = IDX_W'(i);
    end
  end

  assign anyWin = |winVec;
endmodule

// File: rtl/rsCtrl.sv
module rsCtrl
  import rsPkg::*;
#(
  parameter int unsigned AGE_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                issueValid,
  input  logic                issueIsMul,
  input  logic                mulReady,
  input  logic                aluReady,
  input  logic [RS_COUNT-1:0] opsReady,
  output rsStrobe_t           strobe,
  output logic                full,
  output logic                mulGo,
  output logic                aluGo
);
  localparam int unsigned N = RS_COUNT;

  logic [N-1:0]            valid, isMul;
  logic [N-1:0][AGE_W-1:0] age;
  logic [AGE_W-1:0]        ageNext;

  logic [N-1:0] mulCand, aluCand, mulWin, aluWin, relMask, freeVec, alloc;
  rsIdx_t       mulIdx, aluIdx;
  logic         found;

  assign mulCand = valid & isMul  & opsReady & {N{mulReady}};
  assign aluCand = valid & ~isMul & opsReady & {N{aluReady}};

  rsOldestPick #(.N(N), .AGE_W(AGE_W), .IDX_W(RS_IDX_W)) u_mulPick (
    .cand(mulCand), .ages(age), .anyWin(mulGo), .winVec(mulWin), .winIdx(mulIdx)
  );
  rsOldestPick #(.N(N), .AGE_W(AGE_W), .IDX_W(RS_IDX_W)) u_aluPick (
    .cand(aluCand), .ages(age), .anyWin(aluGo), .winVec(aluWin), .winIdx(aluIdx)
  );

  // stations leaving this cycle may be refilled in the same cycle
  assign relMask = mulWin | aluWin;
  assign freeVec = ~valid | relMask;
  assign full    = ~|freeVec;

  always_comb begin
    alloc = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (issueValid && freeVec[i] && !found) begin
        alloc[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assign strobe.alloc  = alloc;
  assign strobe.mulIdx = mulIdx;
  assign strobe.aluIdx = aluIdx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= '0;
      isMul   <= '0;
      age     <= '0;
      ageNext <= '0;
    end else begin
      valid <= (valid & ~relMask) | alloc;
      for (int i = 0; i < N; i++) begin
        if (alloc[i]) begin
          isMul[i] <= issueIsMul;
          age[i]   <= ageNext;
        end
      end
      if (found) ageNext <= ageNext + 1'b1;
    end
  end

  // R4: no multiply leaves while the unit refuses work
  a_r4_mul_gated: assert property (@(posedge clk) disable iff (!rst_n)
    mulGo |-> mulReady);
  // R5: no ALU dispatch while the ALU refuses work
  a_r5_alu_gated: assert property (@(posedge clk) disable iff (!rst_n)
    aluGo |-> aluReady);
  // R5: two dispatches never come from one station
  a_r5_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    (mulGo && aluGo) |-> (mulIdx != aluIdx));
  // R2: at most one instruction enters per cycle
  a_r2_single_entry: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(valid) <= $past($countones(valid)) + 1));
  // R6: a full cycle keeps every station occupied
  a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> (&valid));
endmodule

// File: rtl/rsData.sv
module rsData
  import rsPkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  rsStrobe_t           strobe,
  input  logic                issueSrc1Ready,
  input  logic [DATA_W-1:0]   issueSrc1Val,
  input  logic [TAG_W-1:0]    issueSrc1Tag,
  input  logic                issueSrc2Ready,
  input  logic [DATA_W-1:0]   issueSrc2Val,
  input  logic [TAG_W-1:0]    issueSrc2Tag,
  input  logic [TAG_W-1:0]    issueDstTag,
  input  logic                bcValid,
  input  logic [TAG_W-1:0]    bcTag,
  input  logic [DATA_W-1:0]   bcData,
  output logic [RS_COUNT-1:0] opsReady,
  output logic [DATA_W-1:0]   mulSrc1,
  output logic [DATA_W-1:0]   mulSrc2,
  output logic [TAG_W-1:0]    mulDstTag,
  output logic [DATA_W-1:0]   aluSrc1,
  output logic [DATA_W-1:0]   aluSrc2,
  output logic [TAG_W-1:0]    aluDstTag
);
  localparam int unsigned N = RS_COUNT;

  logic [N-1:0][DATA_W-1:0] val1Arr, val2Arr;
  logic [N-1:0][TAG_W-1:0]  dstArr;
  logic newHit1, newHit2;

  // broadcast hitting an instruction on its way in
  assign newHit1 = bcValid && (bcTag == issueSrc1Tag);
  assign newHit2 = bcValid && (bcTag == issueSrc2Tag);

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic              rdy1q, rdy2q;
    logic [DATA_W-1:0] val1q, val2q;
    logic [TAG_W-1:0]  tag1q, tag2q, dstq;
    logic              oldHit1, oldHit2;

    assign oldHit1 = bcValid && !rdy1q && (tag1q == bcTag);
    assign oldHit2 = bcValid && !rdy2q && (tag2q == bcTag);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdy1q <= 1'b0; rdy2q <= 1'b0;
        val1q <= '0;   val2q <= '0;
        tag1q <= '0;   tag2q <= '0;
        dstq  <= '0;
      end else if (strobe.alloc[i]) begin
        rdy1q <= issueSrc1Ready | newHit1;
        val1q <= issueSrc1Ready ? issueSrc1Val : bcData;
        tag1q <= issueSrc1Tag;
        rdy2q <= issueSrc2Ready | newHit2;
        val2q <= issueSrc2Ready ? issueSrc2Val : bcData;
        tag2q <= issueSrc2Tag;
        dstq  <= issueDstTag;
      end else begin
        if (oldHit1) begin rdy1q <= 1'b1; val1q <= bcData; end
        if (oldHit2) begin rdy2q <= 1'b1; val2q <= bcData; end
      end
    end

    assign opsReady[i] = rdy1q & rdy2q;
    assign val1Arr[i]  = val1q;
    assign val2Arr[i]  = val2q;
    assign dstArr[i]   = dstq;

    // R7: a broadcast met at issue is kept
    a_r7_issue_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe.alloc[i] && !issueSrc1Ready && newHit1)
        |=> (rdy1q && val1q == $past(bcData)));
    // R3: a waiting source wakes on the matching broadcast
    a_r3_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe.alloc[i] && oldHit2) |=> (rdy2q && val2q == $past(bcData)));
    // R3: a ready source stays ready until the station is rewritten
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy1q && !strobe.alloc[i]) |=> rdy1q);
  end

  assign mulSrc1   = val1Arr[strobe.mulIdx];
  assign mulSrc2   = val2Arr[strobe.mulIdx];
  assign mulDstTag = dstArr[strobe.mulIdx];
  assign aluSrc1   = val1Arr[strobe.aluIdx];
  assign aluSrc2   = val2Arr[strobe.aluIdx];
  assign aluDstTag = dstArr[strobe.aluIdx];
endmodule

// File: rtl/rsPool.sv
module rsPool
  import rsPkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 3,
  parameter int unsigned AGE_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issueValid,
  input  logic              issueIsMul,
  input  logic              issueSrc1Ready,
  input  logic [DATA_W-1:0] issueSrc1Val,
  input  logic [TAG_W-1:0]  issueSrc1Tag,
  input  logic              issueSrc2Ready,
  input  logic [DATA_W-1:0] issueSrc2Val,
  input  logic [TAG_W-1:0]  issueSrc2Tag,
  input  logic [TAG_W-1:0]  issueDstTag,
  output logic              full,
  input  logic              bcValid,
  input  logic [TAG_W-1:0]  bcTag,
  input  logic [DATA_W-1:0] bcData,
  input  logic              mulReady,
  input  logic              aluReady,
  output logic              mulGo,
  output logic [DATA_W-1:0] mulSrc1,
  output logic [DATA_W-1:0] mulSrc2,
  output logic [TAG_W-1:0]  mulDstTag,
  output logic              aluGo,
  output logic [DATA_W-1:0] aluSrc1,
  output logic [DATA_W-1:0] aluSrc2,
  output logic [TAG_W-1:0]  aluDstTag
);
  rsStrobe_t           strobe;
  logic [RS_COUNT-1:0] opsReady;

  rsCtrl #(.AGE_W(AGE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .issueValid(issueValid), .issueIsMul(issueIsMul),
    .mulReady(mulReady), .aluReady(aluReady),
    .opsReady(opsReady), .strobe(strobe), .full(full),
    .mulGo(mulGo), .aluGo(aluGo)
  );

  rsData #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_data (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .issueSrc1Ready(issueSrc1Ready), .issueSrc1Val(issueSrc1Val), .issueSrc1Tag(issueSrc1Tag),
    .issueSrc2Ready(issueSrc2Ready), .issueSrc2Val(issueSrc2Val), .issueSrc2Tag(issueSrc2Tag),
    .issueDstTag(issueDstTag),
    .bcValid(bcValid), .bcTag(bcTag), .bcData(bcData),
    .opsReady(opsReady),
    .mulSrc1(mulSrc1), .mulSrc2(mulSrc2), .mulDstTag(mulDstTag),
    .aluSrc1(aluSrc1), .aluSrc2(aluSrc2), .aluDstTag(aluDstTag)
  );
endmodule

// File: tb/rsPool_tb.sv
module rsPool_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic iv = 0, im = 0, r1 = 0, r2 = 0, bv = 0, mr = 0, ar = 0;
  logic [31:0] v1 = 0, v2 = 0, bd = 0;
  logic [2:0] t1 = 0, t2 = 0, dst = 0, bt = 0;
  logic full, mulGo, aluGo;
  logic [31:0] mulSrc1, mulSrc2, aluSrc1, aluSrc2;
  logic [2:0] mulDstTag, aluDstTag;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsPool u_dut (
    .clk(clk), .rst_n(rst_n), .issueValid(iv), .issueIsMul(im),
    .issueSrc1Ready(r1), .issueSrc1Val(v1), .issueSrc1Tag(t1),
    .issueSrc2Ready(r2), .issueSrc2Val(v2), .issueSrc2Tag(t2),
    .issueDstTag(dst), .full(full), .bcValid(bv), .bcTag(bt), .bcData(bd),
    .mulReady(mr), .aluReady(ar),
    .mulGo(mulGo), .mulSrc1(mulSrc1), .mulSrc2(mulSrc2), .mulDstTag(mulDstTag),
    .aluGo(aluGo), .aluSrc1(aluSrc1), .aluSrc2(aluSrc2), .aluDstTag(aluDstTag)
  );

  typedef struct {
    bit isMul; int seq;
    bit ok1; bit [31:0] d1; bit [2:0] g1;
    bit ok2; bit [31:0] d2; bit [2:0] g2;
    bit [2:0] dt;
  } ent_t;

  ent_t pool[$];
  int seqCnt = 0, nTests = 0, nFail = 0, mulSeen = 0;
  bit saw6 = 0, done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  // one cycle: drive at the falling edge, compare, advance the model
  task automatic drive(input bit iv_, im_, r1_, input bit [31:0] v1_, input bit [2:0] t1_,
                       input bit r2_, input bit [31:0] v2_, input bit [2:0] t2_,
                       input bit [2:0] dst_, input bit bv_, input bit [2:0] bt_,
                       input bit [31:0] bd_, input bit mr_, ar_, input string tag);
    int mi, ai;
    bit expFull;
    ent_t e;
    @(negedge clk);
    iv = iv_; im = im_; r1 = r1_; v1 = v1_; t1 = t1_; r2 = r2_; v2 = v2_; t2 = t2_;
    dst = dst_; bv = bv_; bt = bt_; bd = bd_; mr = mr_; ar = ar_;
    #1;
    mi = -1; ai = -1;
    for (int k = 0; k < pool.size(); k++) begin
      if (pool[k].ok1 && pool[k].ok2) begin
        if (pool[k].isMul && mr_ && (mi < 0 || pool[k].seq < pool[mi].seq)) mi = k;
        if (!pool[k].isMul && ar_ && (ai < 0 || pool[k].seq < pool[ai].seq)) ai = k;
      end
    end
    expFull = (pool.size() == 4) && mi < 0 && ai < 0;
    chk(full == expFull, "R6", {tag, " full"}, full, expFull);
    chk(mulGo == (mi >= 0), "R4 R8", {tag, " mulGo"}, mulGo, mi >= 0);
    chk(aluGo == (ai >= 0), "R5 R8", {tag, " aluGo"}, aluGo, ai >= 0);
    if (mi >= 0 && mulGo) begin
      chk(mulDstTag == pool[mi].dt, "R4", {tag, " mulDstTag"}, mulDstTag, pool[mi].dt);
      chk(mulSrc1 == pool[mi].d1 && mulSrc2 == pool[mi].d2, "R3",
          {tag, " mul operands"}, {mulSrc1, mulSrc2}, {pool[mi].d1, pool[mi].d2});
    end
    if (ai >= 0 && aluGo) begin
      chk(aluDstTag == pool[ai].dt, "R5", {tag, " aluDstTag"}, aluDstTag, pool[ai].dt);
      chk(aluSrc1 == pool[ai].d1 && aluSrc2 == pool[ai].d2, "R3",
          {tag, " alu operands"}, {aluSrc1, aluSrc2}, {pool[ai].d1, pool[ai].d2});
    end
    if (mulGo) begin mulSeen++; if (mulDstTag == 3'd6) saw6 = 1; end
    if (mi >= 0 && ai >= 0) begin
      if (mi > ai) begin pool.delete(mi); pool.delete(ai); end
      else begin pool.delete(ai); pool.delete(mi); end
    end else if (mi >= 0) pool.delete(mi);
    else if (ai >= 0) pool.delete(ai);
    if (bv_) begin
      foreach (pool[k]) begin
        if (!pool[k].ok1 && pool[k].g1 == bt_) begin pool[k].ok1 = 1; pool[k].d1 = bd_; end
        if (!pool[k].ok2 && pool[k].g2 == bt_) begin pool[k].ok2 = 1; pool[k].d2 = bd_; end
      end
    end
    if (iv_ && !expFull) begin
      e.isMul = im_; e.seq = seqCnt++; e.dt = dst_;
      e.g1 = t1_; e.ok1 = r1_ || (bv_ && bt_ == t1_); e.d1 = r1_ ? v1_ : bd_;
      e.g2 = t2_; e.ok2 = r2_ || (bv_ && bt_ == t2_); e.d2 = r2_ ? v2_ : bd_;
      pool.push_back(e);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(0,0,1,0,0,1,0,0,0,0,0,0,1,1,"idle");
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(mulGo == 0 && aluGo == 0 && full == 0, "R1", "reset outputs",
        {mulGo, aluGo, full}, 0);
    rst_n = 1'b1;
    drive(0,0,1,0,0,1,0,0,0,0,0,0,1,1,"R1 post-reset");
    chk(!mulGo && !aluGo && !full, "R1", "after release", {mulGo, aluGo, full}, 0);

    // R7: issue with pending src1 while its tag is broadcast
    drive(1,0,0,0,5,1,32'h22,0,1,1,5,32'hABCD,1,1,"R7 issue");
    chk(!aluGo, "R3", "no dispatch in issue cycle", aluGo, 0);
    drive(0,0,1,0,0,1,0,0,0,0,0,0,1,1,"R7 next");
    chk(aluGo && aluSrc1 == 32'hABCD, "R7", "captured at issue", aluSrc1, 32'hABCD);

    // R3: wake one cycle after broadcast
    drive(1,0,0,0,2,1,32'h7,0,3,0,0,0,1,1,"R3 issue");
    drive(0,0,1,0,0,1,0,0,0,0,0,0,1,1,"R3 wait");
    chk(!aluGo, "R3", "pending source blocks", aluGo, 0);
    drive(0,0,1,0,0,1,0,0,0,1,2,32'h55,1,1,"R3 bcast");
    chk(!aluGo, "R3", "no dispatch in broadcast cycle", aluGo, 0);
    drive(0,0,1,0,0,1,0,0,0,0,0,0,1,1,"R3 go");
    chk(aluGo && aluSrc1 == 32'h55, "R3", "dispatch after broadcast", aluSrc1, 32'h55);

    // R2/R6: fill, drop when full, refill in a dispatch cycle
    mulSeen = 0; saw6 = 0;
    for (int k = 0; k < 4; k++)
      drive(1,1,0,0,7,1,k+10,0,3'(k),0,0,0,1,1,"R6 fill");
    drive(1,1,1,1,0,1,1,0,6,0,0,0,1,1,"R2 offer when full");
    chk(full, "R6", "full with four waiting", full, 1);
    drive(0,0,1,0,0,1,0,0,0,1,7,32'h77,1,1,"R3 bcast mul");
    chk(!mulGo, "R3", "no mul in broadcast cycle", mulGo, 0);
    drive(1,0,1,32'h9,0,1,32'h9,0,5,0,0,0,1,1,"R6 refill");
    chk(!full, "R6", "not full during dispatch", full, 0);
    chk(mulGo && mulDstTag == 0, "R4", "oldest mul first", mulDstTag, 0);
    idle(8);
    chk(mulSeen == 4, "R2", "dispatched mul count", mulSeen, 4);
    chk(!saw6, "R2", "dropped instruction never dispatched", saw6, 0);

    // R4 gate: ready mul held while unit busy
    drive(1,1,1,3,0,1,4,0,2,0,0,0,0,1,"R4 issue");
    drive(0,0,1,0,0,1,0,0,0,0,0,0,0,1,"R4 busy");
    chk(!mulGo, "R4", "unit busy blocks", mulGo, 0);
    idle(2);

    // random run, age counter wraps many times (R8)
    for (int c = 0; c < 4000; c++) begin
      bit doIss;
      int minSeq;
      minSeq = seqCnt;
      foreach (pool[k]) if (pool[k].seq < minSeq) minSeq = pool[k].seq;
      doIss = ($urandom % 4 != 0) && (seqCnt - minSeq < 15);
      drive(doIss, $urandom%2, $urandom%3 == 0, $urandom, 3'($urandom),
            $urandom%3 == 0, $urandom, 3'($urandom), 3'($urandom),
            $urandom%2, 3'($urandom), $urandom, $urandom%2, $urandom%4 != 0, "R8 random");
    end
    idle(4);
    finishRun();
  end
endmodule